// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This block produces the partial-write mask for the first and last block of a scan line. It takes two byte addresses: the current position and the last byte of the line. It returns one mask bit per element in the 8-byte block that the first address points into. Elements may be 8, 16 or 32 bits wide, and lanes may be numbered from either end of the mask. When both addresses fall in the same 8-byte block, the run of elements is cut off on both sides. Otherwise only the leading edge is cut off.

A request can also update two sets of integer condition flags. These come from subtracting the second address from the first, seen once as 64-bit values and once as 32-bit values. A 32-bit address mode drops the upper half of each address before the lane offsets are taken and before the blocks are compared. The flags always use the full, untruncated addresses.

The mask and the flags are registered. A request presented for one cycle gives a one-cycle result strobe on the next cycle.

Top module: `edge_mask_gen`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. `res_mask` and the flag outputs change only on the clock edge that ends a request cycle. After reset every output is zero.
- R2: Size code 2'b00 selects 8-bit elements. Code 2'b11 is treated the same way. Lane k (k = 0 to 7) is byte offset k inside the 8-byte block. With `lane_le`=0, lane k drives mask bit 7-k. The leading mask sets the lanes k >= addr_a[2:0]. The trailing mask sets the lanes k <= addr_b[2:0].
- R3: With `lane_le`=1 the lane order is mirrored, so lane k drives mask bit k. For example, offset 3 gives a leading mask of 8'hF8 and a trailing mask of 8'h0F.
- R4: Size code 2'b01 selects 16-bit elements. There are four lanes, the lane offset is address bits [2:1], and bits [7:4] of the mask are zero. Leading masks are F,7,3,1 with `lane_le`=0 and F,E,C,8 with `lane_le`=1. Trailing masks are 8,C,E,F with `lane_le`=0 and 1,3,7,F with `lane_le`=1.
- R5: Size code 2'b10 selects 32-bit elements. There are two lanes, the lane offset is address bit 2, and bits [7:2] of the mask are zero. Leading masks are 3,1 with `lane_le`=0 and 3,2 with `lane_le`=1. Trailing masks are 2,3 with `lane_le`=0 and 1,3 with `lane_le`=1.
- R6: If the two addresses are equal once bits [2:0] are cleared, the result mask is the leading mask AND the trailing mask. Otherwise it is the leading mask alone.
- R7: With `narrow_addr`=1, both addresses are reduced to their low 32 bits for the lane offsets and for the block comparison. The flags still use the full 64-bit values.
- R8: A request with `flag_wr`=1 loads `cc_dword` from addr_a - addr_b over 64 bits and `cc_word` from the same subtraction over the low 32 bits. Each is coded {N,Z,V,C}: N is the result's top bit, Z marks a zero result, V marks two's-complement overflow, and C is the unsigned borrow (set when addr_a is below addr_b).
- R9: A request with `flag_wr`=0 leaves both flag outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| addr_a | input | 64 | Start address |
| addr_b | input | 64 | End address |
| elem_size | input | 2 | 00/11 byte, 01 halfword, 10 word |
| lane_le | input | 1 | Mirrored lane order |
| flag_wr | input | 1 | Update condition flags |
| narrow_addr | input | 1 | 32-bit address mode |
| res_valid | output | 1 | Result strobe |
| res_mask | output | 8 | Edge mask, zero-extended |
| cc_word | output | 4 | {N,Z,V,C} of the 32-bit subtraction |
| cc_dword | output | 4 | {N,Z,V,C} of the 64-bit subtraction |

## Verification
Every lane offset is walked for every element size and both lane orders. One case in each group puts both addresses in the same block, which separates the lone leading mask from the AND of both masks, including the case where the AND is empty.

Pairs of addresses that differ only above bit 31 separate 32-bit mode from 64-bit mode. The same pairs show that the 32-bit flags and the 64-bit flags are computed separately.

Subtraction operands are chosen to separate the flags from one another: equal values, an unsigned borrow, and signed overflow at both bit 31 and bit 63. Interleaved requests with the flag update off show that the flags are held.

// File: rtl/edge_mask_gen.sv
module edge_mask_gen #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [1:0]        elem_size,
  input  logic              lane_le,
  input  logic              flag_wr,
  input  logic              narrow_addr,
  output logic              res_valid,
  output logic [7:0]        res_mask,
  output logic [3:0]        cc_word,
  output logic [3:0]        cc_dword
);
  localparam logic [ADDR_W-1:0] NARROW_KEEP = ADDR_W'({NARROW_W{1'b1}});

  logic [ADDR_W-1:0]   ta, tb, diff_d;
  logic [NARROW_W-1:0] diff_w;
  logic [7:0]          lead, trail, mask_d;
  logic                same_blk;
  logic [3:0]          flags_w, flags_d;

  assign ta = narrow_addr ? (addr_a & NARROW_KEEP) : addr_a;
  assign tb = narrow_addr ? (addr_b & NARROW_KEEP) : addr_b;
  assign same_blk = (ta[ADDR_W-1:3] == tb[ADDR_W-1:3]);

  always_comb begin
    lead  = '0;
    trail = '0;
    case (elem_size)
      2'b01: begin
        lead[3:0]  = lane_le ? (4'hF << ta[2:1]) : (4'hF >> ta[2:1]);
        trail[3:0] = lane_le ? (4'hF >> (2'd3 - tb[2:1])) : (4'hF << (2'd3 - tb[2:1]));
      end
      2'b10: begin
        lead[1:0]  = lane_le ? (2'b11 << ta[2]) : (2'b11 >> ta[2]);
        trail[1:0] = lane_le ? (2'b11 >> !tb[2]) : (2'b11 << !tb[2]);
      end
      default: begin
        lead  = lane_le ? (8'hFF << ta[2:0]) : (8'hFF >> ta[2:0]);
        trail = lane_le ? (8'hFF >> (3'd7 - tb[2:0])) : (8'hFF << (3'd7 - tb[2:0]));
      end
    endcase
  end

  assign mask_d = same_blk ? (lead & trail) : lead;

  assign diff_d = addr_a - addr_b;
  assign diff_w = addr_a[NARROW_W-1:0] - addr_b[NARROW_W-1:0];

  assign flags_d = {diff_d[ADDR_W-1], diff_d == '0,
                    (addr_a[ADDR_W-1] ^ addr_b[ADDR_W-1]) & (diff_d[ADDR_W-1] ^ addr_a[ADDR_W-1]),
                    addr_a < addr_b};
  assign flags_w = {diff_w[NARROW_W-1], diff_w == '0,
                    (addr_a[NARROW_W-1] ^ addr_b[NARROW_W-1]) & (diff_w[NARROW_W-1] ^ addr_a[NARROW_W-1]),
                    addr_a[NARROW_W-1:0] < addr_b[NARROW_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_mask  <= '0;
      cc_word   <= '0;
      cc_dword  <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_mask <= mask_d;
        if (flag_wr) begin
          cc_word  <= flags_w;
          cc_dword <= flags_d;
        end
      end
    end
  end

  a_r1_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && $stable(res_mask));
  a_r9_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && flag_wr) |=> $stable(cc_word) && $stable(cc_dword));
  a_r4_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && elem_size == 2'b01) |=> res_mask[7:4] == 4'h0);
  a_r5_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && elem_size == 2'b10) |=> res_mask[7:2] == 6'h0);
  a_r8_zero_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    cc_dword[2] |-> !cc_dword[0] && !cc_dword[1]);
endmodule

// File: tb/edge_mask_gen_bench.sv
module edge_mask_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] addr_a = '0, addr_b = '0;
  logic [1:0]  elem_size = '0;
  logic        lane_le = 1'b0, flag_wr = 1'b0, narrow_addr = 1'b0;
  logic        res_valid;
  logic [7:0]  res_mask;
  logic [3:0]  cc_word, cc_dword;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [3:0]  mdl_w = '0, mdl_d = '0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  edge_mask_gen u_edge_mask_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr_a(addr_a), .addr_b(addr_b),
    .elem_size(elem_size), .lane_le(lane_le), .flag_wr(flag_wr), .narrow_addr(narrow_addr),
    .res_valid(res_valid), .res_mask(res_mask), .cc_word(cc_word), .cc_dword(cc_dword));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_mask(logic [63:0] a, logic [63:0] b,
                                            logic [1:0] sz, logic le, logic nar);
    logic [63:0] xa, xb;
    logic [7:0]  l, r;
    int lanes, sh, o1, o2;
    xa = nar ? {32'h0, a[31:0]} : a;
    xb = nar ? {32'h0, b[31:0]} : b;
    lanes = (sz == 2'b01) ? 4 : (sz == 2'b10) ? 2 : 8;
    sh    = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 0;
    o1 = int'(xa[2:0]) >> sh;
    o2 = int'(xb[2:0]) >> sh;
    l = '0; r = '0;
    for (int k = 0; k < lanes; k++) begin
      int bp;
      bp = le ? k : lanes - 1 - k;
      l[bp] = (k >= o1);
      r[bp] = (k <= o2);
    end
    return ((xa >> 3) == (xb >> 3)) ? (l & r) : l;
  endfunction

  function automatic logic [3:0] model_cc64(logic [63:0] a, logic [63:0] b);
    logic [63:0] d;
    logic n, lt;
    d = a - b;
    n = d[63];
    lt = $signed(a) < $signed(b);
    return {n, d == 64'h0, n ^ lt, a < b};
  endfunction

  function automatic logic [3:0] model_cc32(logic [31:0] a, logic [31:0] b);
    logic [31:0] d;
    logic n, lt;
    d = a - b;
    n = d[31];
    lt = $signed(a) < $signed(b);
    return {n, d == 32'h0, n ^ lt, a < b};
  endfunction

  task automatic issue(input string tag, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] sz, input logic le, input logic fw, input logic nar);
    @(negedge clk);
    addr_a = a; addr_b = b; elem_size = sz; lane_le = le; flag_wr = fw; narrow_addr = nar;
    req_valid = 1'b1;
    if (fw) begin
      mdl_w = model_cc32(a[31:0], b[31:0]);
      mdl_d = model_cc64(a, b);
    end
    exp_q.push_back({model_mask(a, b, sz, le, nar), mdl_w, mdl_d});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected strobe", 16'h1, 16'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " mask"}, {8'h0, res_mask}, {8'h0, e[15:8]});
        check({t, " cc_word"}, {12'h0, cc_word}, {12'h0, e[7:4]});
        check({t, " cc_dword"}, {12'h0, cc_dword}, {12'h0, e[3:0]});
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {3'b0, res_valid, res_mask, cc_word}, 16'h0);
    check("R1 reset flags", {12'h0, cc_dword}, 16'h0);
    rst_n = 1'b1;
    // R2 R3 R4 R5 every offset, far end in another block (leading mask only)
    for (int s = 0; s < 4; s++)
      for (int le = 0; le < 2; le++)
        for (int o = 0; o < 8; o++)
          issue("R2/R3/R4/R5 lead", 64'h1000 + 64'(o), 64'h2000 + 64'(7 - o),
                2'(s), 1'(le), 1'b0, 1'b0);
    // R6 same block, all offset pairs per size and order
    for (int s = 0; s < 3; s++)
      for (int le = 0; le < 2; le++)
        for (int o1 = 0; o1 < 8; o1++)
          for (int o2 = 0; o2 < 8; o2++)
            issue("R6 same block", 64'h40 + 64'(o1), 64'h40 + 64'(o2), 2'(s), 1'(le), 1'b0, 1'b0);
    // R7 upper halves differ: narrow ANDs, wide does not
    issue("R7 narrow", 64'hAAAA_0000_0000_0012, 64'h5555_0000_0000_0015, 2'b00, 1'b0, 1'b1, 1'b1);
    issue("R7 wide", 64'hAAAA_0000_0000_0012, 64'h5555_0000_0000_0015, 2'b00, 1'b0, 1'b1, 1'b0);
    issue("R7 narrow le", 64'h1_0000_0003, 64'h2_0000_0006, 2'b01, 1'b1, 1'b1, 1'b1);
    // R8 flags corner cases
    issue("R8 equal", 64'h1234, 64'h1234, 2'b00, 1'b0, 1'b1, 1'b0);
    issue("R8 borrow", 64'h5, 64'h9, 2'b00, 1'b0, 1'b1, 1'b0);
    issue("R8 ovf64", 64'h8000_0000_0000_0000, 64'h1, 2'b10, 1'b0, 1'b1, 1'b0);
    issue("R8 ovf32", 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 1'b0, 1'b1, 1'b0);
    issue("R8 hi only", 64'h0000_0002_0000_0010, 64'h0000_0001_0000_0010, 2'b00, 1'b1, 1'b1, 1'b0);
    // R9 no-update requests keep the previous flags
    issue("R9 hold", 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 1'b0, 1'b0, 1'b0);
    issue("R9 hold2", 64'h7, 64'h7, 2'b10, 1'b1, 1'b0, 1'b1);
    issue("R8 after hold", 64'h0, 64'h1, 2'b00, 1'b0, 1'b1, 1'b0);
    // R1 back-to-back requests followed by idle cycles
    @(negedge clk);
    addr_a = 64'h3; addr_b = 64'h100; elem_size = 2'b00; lane_le = 1'b0; flag_wr = 1'b0; narrow_addr = 1'b0;
    req_valid = 1'b1;
    exp_q.push_back({model_mask(64'h3, 64'h100, 2'b00, 1'b0, 1'b0), mdl_w, mdl_d});
    tag_q.push_back("R1 back-to-back a");
    @(negedge clk);
    addr_a = 64'h6;
    exp_q.push_back({model_mask(64'h6, 64'h100, 2'b00, 1'b0, 1'b0), mdl_w, mdl_d});
    tag_q.push_back("R1 back-to-back b");
    @(negedge clk);
    req_valid = 1'b0;
    addr_a = 64'h0;
    repeat (3) @(negedge clk);
    check("R1 idle", {15'h0, res_valid}, 16'h0);
    check("R1 held mask", {8'h0, res_mask}, {8'h0, model_mask(64'h6, 64'h100, 2'b00, 1'b0, 1'b0)});
    check("R1 queue drained", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule